// File: doc/BRIEF.md
# Output Pair Guard with Dead-Time Insertion

This block sits between the logic that computes output pin values and the pins themselves. The pins are grouped into pairs, two pairs per output block. Each pair can be armed once by a command write. When a pair is armed, it records its present two-bit value as the resting code. The bitwise inverse of that code is then never allowed onto the pins. If the source asks for the inverse code, the pair shows the resting code instead.

Every change of an armed pair's requested value is sequenced. The pair first drops to the resting code. It holds there for a dead time, then moves on to the new value. The dead time is timed by one free-running divider that is shared by all pairs, with its modulus set by an input. The dead time is therefore not exact, but it always falls inside a known window.

Unarmed pairs pass their requested values straight through. Arming is permanent until the synchronous hardware reset.

Top module: `pinpair_guard_top`

## Requirements
- R1: An unarmed pair drives `pins_out` equal to its bits of `req_pins` in the same cycle, with no register on the path.
- R2: A command takes effect when `cmd_wr` is high at a rising clock edge. `cmd_byte[3:1]` selects block b and `cmd_byte[0]` selects pair s. This arms pair index p = {b,s}, which owns pin bits 4b+2s+1 down to 4b+2s. Bits 7:4 of the byte are ignored.
- R3: At the arming edge, the pair stores its requested value as the resting code. From that edge on, the pair shows the resting code until a different request is seen.
- R4: On an armed pair, a request equal to the bitwise inverse of the resting code is treated as a request for the resting code. The inverse code never appears on that pair's pins.
- R5: When an armed pair sees its screened request differ from its current target at an edge, its pins show the resting code from that edge. They keep showing it until the edge that brings the second divider terminal count after that start edge. After that edge the pins show the new value. A move between two different non-resting codes therefore always passes through the resting code.
- R6: The divider counts up from 0 after reset. It gives a terminal count whenever its count is at least `dead_n`, and returns to 0 on that cycle. With a steady `dead_n` of n, the resting code is held for between n+1 and 2n+2 cycles.
- R7: If the screened request changes again while a dead time is running, the pins stay at the resting code and the dead time starts over from that edge.
- R8: Arming is sticky. Further commands to an armed pair do not capture a new resting code. Only `rst` returns a pair to pass-through.
- R9: Pairs are independent. Arming, screening or sequencing one pair never changes the pins of another pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset; disarms every pair |
| cmd_wr | input | 1 | Command strobe, sampled at the clock edge |
| cmd_byte | input | 8 | Arming command: bits 3:1 block, bit 0 pair, bits 7:4 ignored |
| dead_n | input | PRE_W | Dead-time divider constant n (modulus n+1) |
| req_pins | input | 4*NBLK | Requested pin values, two bits per pair |
| pins_out | output | 4*NBLK | Guarded pin values |

## Verification
The bench drives pseudo-random words on unarmed pairs to show that they pass straight through. It then arms pairs with different resting codes (00, 10 and 11), so that screening is shown to follow the captured code and not a fixed one. For sequencing, it makes moves between two active codes, moves into and out of the resting code, forbidden requests and a request that changes again during the dead time. It repeats these at divider constants 0, 3, 5 and 20, and lowers the constant while a count is running. The bench counts the resting cycles of each move and checks them against the n+1 to 2n+2 window. It also re-sends arming commands to armed pairs and applies a hardware reset, to separate sticky arming from recapture.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int CMD_W     = 8;
    localparam int SEL_BITS  = 4;   // cmd_byte[3:0] = {block, pair}
    localparam int PAIR_W    = 2;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,   // showing the target value
        PH_WAIT1 = 2'd1,   // resting, waiting for first terminal count
        PH_WAIT2 = 2'd2    // resting, waiting for second terminal count
    } dt_phase_e;

    typedef struct packed {
        logic      armed;
        pair_t     safe;
        pair_t     tgt;
        dt_phase_e phase;
    } guard_st_t;

    localparam guard_st_t GUARD_RESET = '{armed: 1'b0, safe: '0, tgt: '0, phase: PH_HOLD};

    // Replace the forbidden code (inverse of the resting code) by the resting code.
    function automatic pair_t screen(pair_t req, pair_t safe);
        return (req == ~safe) ? safe : req;
    endfunction

    // Value presented on the pins for a given guard state.
    function automatic pair_t present(guard_st_t st, pair_t req);
        if (!st.armed)
            return req;
        else if (st.phase != PH_HOLD)
            return st.safe;
        else
            return st.tgt;
    endfunction

endpackage

// File: rtl/pp_dt_divider.sv
module pp_dt_divider #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] limit,
    output logic             tc
);
    logic [PRE_W-1:0] cnt_q;

    // ">=" so that lowering the limit mid-count still wraps promptly
    assign tc = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tc)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pp_cmd_decode.sv
module pp_cmd_decode
    import pp_pkg::*;
#(
    parameter int NPAIR = 16
) (
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic [NPAIR-1:0] arm
);
    logic [SEL_BITS-1:0] sel;
    logic                unused_rsvd;

    assign sel         = cmd_byte[SEL_BITS-1:0];
    assign unused_rsvd = ^cmd_byte[CMD_W-1:SEL_BITS];

    for (genvar p = 0; p < NPAIR; p++) begin : g_arm
        assign arm[p] = cmd_wr && (sel == SEL_BITS'(p));
    end
endmodule

// File: rtl/pp_pair_guard.sv
module pp_pair_guard
    import pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  arm,
    input  logic  tc,
    input  pair_t req,
    output pair_t pins,
    output logic  armed,
    output pair_t safe
);
    guard_st_t st_q;
    pair_t     want;

    always_comb begin
        want = screen(req, st_q.safe);
        pins = present(st_q, req);
    end

    assign armed = st_q.armed;
    assign safe  = st_q.safe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= GUARD_RESET;
        end else if (!st_q.armed) begin
            if (arm) begin
                st_q.armed <= 1'b1;
                st_q.safe  <= req;
                st_q.tgt   <= req;
                st_q.phase <= PH_HOLD;
            end
        end else if (want != st_q.tgt) begin
            // new target: (re)start the dead time
            st_q.tgt   <= want;
            st_q.phase <= PH_WAIT1;
        end else if (tc) begin
            unique case (st_q.phase)
                PH_WAIT1: st_q.phase <= PH_WAIT2;
                PH_WAIT2: st_q.phase <= PH_HOLD;
                default:  st_q.phase <= st_q.phase;
            endcase
        end
    end
endmodule

// File: rtl/pinpair_guard_top.sv
module pinpair_guard_top
    import pp_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_byte,
    input  logic [PRE_W-1:0]  dead_n,
    input  logic [4*NBLK-1:0] req_pins,
    output logic [4*NBLK-1:0] pins_out
);
    localparam int NPAIR = 2 * NBLK;

    logic [NPAIR-1:0]        arm;
    logic [NPAIR-1:0]        pair_en;
    logic [2*NPAIR-1:0]      pair_safe;
    logic                    tc;

    pp_dt_divider #(.PRE_W(PRE_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .limit (dead_n),
        .tc    (tc)
    );

    pp_cmd_decode #(.NPAIR(NPAIR)) u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_byte (cmd_byte),
        .arm      (arm)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pp_pair_guard u_guard (
            .clk   (clk),
            .rst   (rst),
            .arm   (arm[p]),
            .tc    (tc),
            .req   (req_pins[2*p +: 2]),
            .pins  (pins_out[2*p +: 2]),
            .armed (pair_en[p]),
            .safe  (pair_safe[2*p +: 2])
        );
    end
endmodule

// File: rtl/pp_guard_chk.sv
module pp_guard_chk #(
    parameter int NPAIR = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [2*NPAIR-1:0] req_pins,
    input logic [2*NPAIR-1:0] pins_out,
    input logic [NPAIR-1:0]   pair_en,
    input logic [2*NPAIR-1:0] pair_safe
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
            !pair_en[p] |-> pins_out[2*p +: 2] == req_pins[2*p +: 2])
            else $error("pair %0d unarmed but not passing through", p);

        assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(pair_en[p]) |-> (pair_safe[2*p +: 2] == $past(req_pins[2*p +: 2]))
                                  && (pins_out[2*p +: 2] == pair_safe[2*p +: 2]))
            else $error("pair %0d resting code not captured", p);

        assert_no_forbidden_R4: assert property (@(posedge clk) disable iff (rst)
            pair_en[p] |-> pins_out[2*p +: 2] != ~pair_safe[2*p +: 2])
            else $error("pair %0d shows forbidden code", p);

        assert_via_safe_R5: assert property (@(posedge clk) disable iff (rst)
            (pair_en[p] && $past(pair_en[p])
             && pins_out[2*p +: 2] != pair_safe[2*p +: 2]
             && $past(pins_out[2*p +: 2]) != pair_safe[2*p +: 2])
            |-> pins_out[2*p +: 2] == $past(pins_out[2*p +: 2]))
            else $error("pair %0d skipped the resting code", p);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            pair_en[p] |=> pair_en[p])
            else $error("pair %0d disarmed without reset", p);
    end
endmodule

bind pinpair_guard_top pp_guard_chk #(.NPAIR(2*NBLK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_pins  (req_pins),
    .pins_out  (pins_out),
    .pair_en   (pair_en),
    .pair_safe (pair_safe)
);

// File: tb/tb_pinpair_guard_top.sv
module tb_pinpair_guard_top;
    localparam int CLK_PERIOD = 10;
    localparam int NBLK  = 8;
    localparam int NPAIR = 2 * NBLK;
    localparam int NPIN  = 4 * NBLK;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_wr = 1'b0;
    logic [7:0]      cmd_byte = '0;
    logic [7:0]      dead_n = '0;
    logic [NPIN-1:0] req_pins = '0;
    logic [NPIN-1:0] pins_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinpair_guard_top #(.NBLK(NBLK), .PRE_W(8)) dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .dead_n(dead_n), .req_pins(req_pins), .pins_out(pins_out)
    );

    typedef struct {
        logic [NPIN-1:0] exp;
        string           tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // reference model built from the requirements
    logic       m_en   [NPAIR];
    logic [1:0] m_safe [NPAIR];
    logic [1:0] m_tgt  [NPAIR];
    int         m_ph   [NPAIR];
    int         m_pc;

    function automatic logic [NPIN-1:0] model_out();
        logic [NPIN-1:0] o;
        for (int p = 0; p < NPAIR; p++) begin
            if (!m_en[p])        o[2*p +: 2] = req_pins[2*p +: 2];
            else if (m_ph[p] != 0) o[2*p +: 2] = m_safe[p];
            else                 o[2*p +: 2] = m_tgt[p];
        end
        return o;
    endfunction

    task automatic model_edge();
        logic tick;
        logic [1:0] r, f;
        if (rst) begin
            m_pc = 0;
            for (int p = 0; p < NPAIR; p++) begin
                m_en[p] = 1'b0; m_safe[p] = '0; m_tgt[p] = '0; m_ph[p] = 0;
            end
        end else begin
            tick = (m_pc >= int'(dead_n));
            m_pc = tick ? 0 : m_pc + 1;
            for (int p = 0; p < NPAIR; p++) begin
                r = req_pins[2*p +: 2];
                if (!m_en[p]) begin
                    if (cmd_wr && int'(cmd_byte[3:0]) == p) begin
                        m_en[p] = 1'b1; m_safe[p] = r; m_tgt[p] = r; m_ph[p] = 0;
                    end
                end else begin
                    f = (r == ~m_safe[p]) ? m_safe[p] : r;
                    if (f != m_tgt[p]) begin
                        m_tgt[p] = f; m_ph[p] = 1;
                    end else if (tick && m_ph[p] == 1) m_ph[p] = 2;
                    else if (tick && m_ph[p] == 2) m_ph[p] = 0;
                end
            end
        end
    endtask

    // driver step: inputs already set after a negedge
    task automatic step();
        item_t it;
        @(posedge clk);
        model_edge();
        it.exp = model_out();
        it.tag = cur_tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        item_t got;
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            got = q.pop_front();
            n_cmp++;
            if (pins_out !== got.exp) begin
                n_bad++;
                $display("FAIL %s: pins_out actual=%h expected=%h", got.tag, pins_out, got.exp);
            end
        end
    end

    // measure resting cycles of pair 0 after its request moves to 'to'
    task automatic measure(string tag, logic [1:0] to, logic [1:0] safe, int n);
        int cnt = 0;
        req_pins[1:0] = to;
        for (int i = 0; i < 600; i++) begin
            step();
            if (pins_out[1:0] == safe) cnt++;
            else break;
        end
        chk(tag, NPIN'(pins_out[1:0]), NPIN'(to));
        n_cmp++;
        if (cnt < n + 1 || cnt > 2*n + 2) begin
            n_bad++;
            $display("FAIL %s: dead cycles actual=%0d expected=%0d..%0d", tag, cnt, n + 1, 2*n + 2);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1..: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;

        // R1: unarmed pass-through under varied words
        cur_tag = "R1";
        for (int i = 0; i < 8; i++) begin
            req_pins = NPIN'(32'h9E3779B9 * (i + 1));
            step();
        end
        chk("R1", pins_out, req_pins);

        // R2/R3: arm pair 0 (byte F0, reserved bits set) and pair 11 (byte 0B)
        cur_tag = "R2";
        req_pins = (32'h5A5A5A5A & ~32'h00C00003) | 32'h00800000;
        cmd_wr = 1'b1; cmd_byte = 8'hF0; step();
        cmd_byte = 8'h0B; step();
        cmd_wr = 1'b0;
        cur_tag = "R3";
        step();
        chk("R3", NPIN'(pins_out[1:0]), NPIN'(2'b00));
        chk("R3", NPIN'(pins_out[23:22]), NPIN'(2'b10));
        // pair 1 (pins 3:2) not armed: still follows request (R2 bit 0 decode)
        req_pins[3:2] = ~req_pins[3:2];
        step();
        chk("R2", NPIN'(pins_out[3:2]), NPIN'(req_pins[3:2]));

        // R4: forbidden requests shown as resting code
        cur_tag = "R4";
        req_pins[1:0] = 2'b11;
        req_pins[23:22] = 2'b01;
        repeat (6) step();
        chk("R4", NPIN'(pins_out[1:0]), NPIN'(2'b00));
        chk("R4", NPIN'(pins_out[23:22]), NPIN'(2'b10));

        // R5/R6: sequenced moves at several divider constants
        cur_tag = "R5";
        dead_n = 8'd3;
        req_pins[1:0] = 2'b01;
        repeat (12) step();
        chk("R5", NPIN'(pins_out[1:0]), NPIN'(2'b01));
        cur_tag = "R6";
        measure("R6", 2'b10, 2'b00, 3);
        dead_n = 8'd0;
        repeat (2) step();
        measure("R6", 2'b01, 2'b00, 0);
        dead_n = 8'd20;
        repeat (25) step();
        measure("R5", 2'b10, 2'b00, 20);
        // move from a rested active code into the resting code and back out
        cur_tag = "R5";
        req_pins[1:0] = 2'b00;
        repeat (50) step();
        chk("R5", NPIN'(pins_out[1:0]), NPIN'(2'b00));

        // R7: retrigger during dead time
        cur_tag = "R7";
        dead_n = 8'd5;
        req_pins[1:0] = 2'b01;
        repeat (3) step();
        chk("R7", NPIN'(pins_out[1:0]), NPIN'(2'b00));
        req_pins[1:0] = 2'b10;
        repeat (5) step();
        chk("R7", NPIN'(pins_out[1:0]), NPIN'(2'b00));
        repeat (10) step();
        chk("R7", NPIN'(pins_out[1:0]), NPIN'(2'b10));

        // R8: re-arming an armed pair keeps the old resting code
        cur_tag = "R8";
        req_pins[1:0] = 2'b01;
        repeat (15) step();
        cmd_wr = 1'b1; cmd_byte = 8'h00; step();
        cmd_wr = 1'b0;
        req_pins[1:0] = 2'b10;
        repeat (15) step();
        chk("R8", NPIN'(pins_out[1:0]), NPIN'(2'b10));
        req_pins[1:0] = 2'b11;
        repeat (15) step();
        chk("R8", NPIN'(pins_out[1:0]), NPIN'(2'b00));
        rst = 1'b1; step();
        rst = 1'b0;
        req_pins = 32'hC3A5_0F96;
        step();
        chk("R8", pins_out, req_pins);

        // R9: independent pairs; pair 5 resting 11, pair 0 resting 10
        cur_tag = "R9";
        dead_n = 8'd200;
        req_pins[11:10] = 2'b11;
        req_pins[1:0]   = 2'b10;
        cmd_wr = 1'b1; cmd_byte = 8'h05; step();
        cmd_byte = 8'h00; step();
        cmd_wr = 1'b0;
        req_pins[11:10] = 2'b01;
        req_pins[1:0]   = 2'b00;
        req_pins[15:14] = 2'b01;
        repeat (4) step();
        chk("R9", NPIN'(pins_out[15:14]), NPIN'(2'b01));
        chk("R9", NPIN'(pins_out[11:10]), NPIN'(2'b11));
        dead_n = 8'd2;   // lowered mid-count (R6)
        req_pins[11:10] = 2'b00;  // forbidden for pair 5 -> rests at 11
        repeat (12) step();
        chk("R9", NPIN'(pins_out[11:10]), NPIN'(2'b11));
        chk("R9", NPIN'(pins_out[1:0]), NPIN'(2'b00));

        repeat (2) step();
        @(posedge clk); #(CLK_PERIOD/2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule